// File: doc/BRIEF.md
# Range-Based Remote Address Translator

This block sits between a 32-bit processor bus and a network interface. It has one lookup path for instruction fetches and one for data accesses. For each path it decides whether the presented address belongs to a remote node. The decision comes from a small table of range entries. Each entry holds an inclusive lower bound, an inclusive upper bound, a destination host number, a kind bit that marks the range as memory space or I/O space, and a valid bit.

Every cycle each path reports the number of the matching entry and a remote flag. Entries are numbered from 1, and the number 0 means no entry matched. When the processor strobes an access that falls in a remote range, the path stalls the processor through an active-low ready line. It then raises a one-cycle network request that carries the host number, the address and the kind bit. It keeps the stall until the network side returns a completion strobe. The cycle after the completion is a grant cycle: the stall is lifted and the processor can finish the access. Frame building is left to the network side; the request/completion pair stands in for it.

The table is loaded through a write port. The port takes a zero-based slot, both bounds, the host number, the kind bit and the valid bit.

Top module: `range_remote_xlate`

## Requirements
- R1: An entry matches when its lower bound <= address <= its upper bound, with both bounds included. The hit output gives slot+1 of the matching entry, and 0 when nothing matches. This is combinational in the same cycle as the address.
- R2: When several entries match, the hit output gives the lowest-numbered one.
- R3: An entry whose valid bit is 0 never matches. Reset clears every valid bit, so after reset every address reports hit 0.
- R4: The remote flag of a path is 1 exactly when its hit output is nonzero. It is combinational.
- R5: The ready line (active low, 1 = stall) is 1 in the cycle a strobed access hits a remote range, and in every cycle while that request is outstanding. A strobed access that hits nothing, or no strobe at all, gives 0.
- R6: The network request is 1 for exactly one cycle: the cycle after the strobed remote hit. With it come the matched entry's host number, the address, and the kind bit (0 = memory space, 1 = I/O space).
- R7: The ready line returns to 0 on the cycle after a completion strobe. In that grant cycle no new request is raised, even though the strobe is still held. A completion strobe while nothing is outstanding has no effect.
- R8: The instruction path and the data path stall, request and complete independently of each other.
- R9: A table write takes effect for lookups from the cycle after the write edge. Slot s reports as hit number s+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Table write enable |
| cfg_slot | input | SLOT_W | Zero-based slot to write |
| cfg_lo | input | AW | Inclusive lower bound |
| cfg_hi | input | AW | Inclusive upper bound |
| cfg_host | input | HOST_W | Destination host number |
| cfg_io | input | 1 | Kind: 0 memory, 1 I/O |
| cfg_valid | input | 1 | Entry valid |
| if_addr | input | AW | Instruction fetch address |
| if_strobe | input | 1 | Instruction fetch active |
| if_hit | output | HIT_W | Matching entry number, 0 = none |
| if_remote | output | 1 | Instruction address is remote |
| if_rdy_n | output | 1 | Instruction stall (active-low ready) |
| if_net_req | output | 1 | Instruction network request pulse |
| if_net_host | output | HOST_W | Request host number |
| if_net_addr | output | AW | Request address |
| if_net_io | output | 1 | Request kind |
| if_net_cmp | input | 1 | Instruction network completion strobe |
| dt_addr | input | AW | Data access address |
| dt_strobe | input | 1 | Data access active |
| dt_hit | output | HIT_W | Matching entry number, 0 = none |
| dt_remote | output | 1 | Data address is remote |
| dt_rdy_n | output | 1 | Data stall (active-low ready) |
| dt_net_req | output | 1 | Data network request pulse |
| dt_net_host | output | HOST_W | Request host number |
| dt_net_addr | output | AW | Request address |
| dt_net_io | output | 1 | Request kind |
| dt_net_cmp | input | 1 | Data network completion strobe |

## Verification
A corrupted table register shows up as a wrong hit number in the very next cycle that a lookup touches that entry. So the bench compares hit numbers near every bound against a model, across several tables, including overlapping ones. A path state machine stuck in the wrong state shows within one or two cycles. It appears as a stall that never starts, a stall that never ends, a repeated request, or a request during the grant cycle. Every handshake is therefore traced cycle by cycle with varied completion delays, on both paths. Completion strobes that arrive while the path is idle are checked for having no effect.

// File: rtl/xlate_pkg.sv
// Shared types for the range-based remote address translator.
package xlate_pkg;
    // Per-path handshake state.
    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_WAIT  = 2'd1,
        PS_GRANT = 2'd2
    } path_state_e;
endpackage

// File: rtl/xlate_table.sv
// Range table storage.
// Holds N_ENTRY entries of {valid, kind, host, lo, hi} and updates one slot per write.
// Assumes slot indices >= N_ENTRY are dropped. Reset clears all valid bits.
module xlate_table #(
    parameter int N_ENTRY = 4,
    parameter int AW      = 32,
    parameter int HOST_W  = 8,
    localparam int SLOT_W = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [SLOT_W-1:0]             slot,
    input  logic [AW-1:0]                 lo_in,
    input  logic [AW-1:0]                 hi_in,
    input  logic [HOST_W-1:0]             host_in,
    input  logic                          io_in,
    input  logic                          valid_in,
    output logic [N_ENTRY-1:0][AW-1:0]    lo,
    output logic [N_ENTRY-1:0][AW-1:0]    hi,
    output logic [N_ENTRY-1:0][HOST_W-1:0] host,
    output logic [N_ENTRY-1:0]            io,
    output logic [N_ENTRY-1:0]            valid
);
    for (genvar g = 0; g < N_ENTRY; g++) begin : g_ent
        // Store one entry; loaded when the write selects this slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo[g]    <= '0;
                hi[g]    <= '0;
                host[g]  <= '0;
                io[g]    <= 1'b0;
                valid[g] <= 1'b0;
            end else if (we && (int'(slot) == g)) begin
                lo[g]    <= lo_in;
                hi[g]    <= hi_in;
                host[g]  <= host_in;
                io[g]    <= io_in;
                valid[g] <= valid_in;
            end
        end
    end
endmodule

// File: rtl/xlate_match.sv
// Priority range matcher.
// Compares one address against every valid entry with inclusive bounds.
// It returns slot+1 of the lowest matching slot (0 if none), plus that entry's host and kind.
// Purely combinational.
module xlate_match #(
    parameter int N_ENTRY = 4,
    parameter int AW      = 32,
    parameter int HOST_W  = 8,
    localparam int HIT_W  = $clog2(N_ENTRY + 1)
) (
    input  logic [AW-1:0]                  addr,
    input  logic [N_ENTRY-1:0][AW-1:0]     lo,
    input  logic [N_ENTRY-1:0][AW-1:0]     hi,
    input  logic [N_ENTRY-1:0][HOST_W-1:0] host,
    input  logic [N_ENTRY-1:0]             io,
    input  logic [N_ENTRY-1:0]             valid,
    output logic [HIT_W-1:0]               hit_num,
    output logic [HOST_W-1:0]              hit_host,
    output logic                           hit_io
);
    logic [N_ENTRY-1:0] in_range;

    // Per-entry inclusive range test.
    for (genvar g = 0; g < N_ENTRY; g++) begin : g_cmp
        assign in_range[g] = valid[g] && (lo[g] <= addr) && (addr <= hi[g]);
    end

    // Priority pick: scan downward so the lowest slot is written last.
    always_comb begin
        hit_num  = '0;
        hit_host = '0;
        hit_io   = 1'b0;
        for (int i = N_ENTRY - 1; i >= 0; i--) begin
            if (in_range[i]) begin
                hit_num  = HIT_W'(i + 1);
                hit_host = host[i];
                hit_io   = io[i];
            end
        end
    end
endmodule

// File: rtl/xlate_path.sv
// Remote access handshake for one bus path.
// It stalls the CPU on a strobed remote hit and issues a one-cycle request.
// It waits for the completion strobe, then grants for one cycle.
// Assumes the CPU holds its address and strobe while stalled.
module xlate_path #(
    parameter int AW     = 32,
    parameter int HOST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic              strobe,
    input  logic              remote,
    input  logic [HOST_W-1:0] hit_host,
    input  logic              hit_io,
    input  logic              net_cmp,
    output logic              rdy_n,
    output logic              net_req,
    output logic [HOST_W-1:0] net_host,
    output logic [AW-1:0]     net_addr,
    output logic              net_io
);
    import xlate_pkg::*;

    path_state_e st;
    logic        start;

    assign start = (st == PS_IDLE) && strobe && remote;
    assign rdy_n = (st == PS_WAIT) || start;

    // Handshake state: idle -> wait on remote strobe, wait -> grant on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= PS_IDLE;
        end else begin
            case (st)
                PS_IDLE:  if (start) st <= PS_WAIT;
                PS_WAIT:  if (net_cmp) st <= PS_GRANT;
                default:  st <= PS_IDLE;
            endcase
        end
    end

    // Request pulse and captured payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            net_req  <= 1'b0;
            net_host <= '0;
            net_addr <= '0;
            net_io   <= 1'b0;
        end else begin
            net_req <= start;
            if (start) begin
                net_host <= hit_host;
                net_addr <= addr;
                net_io   <= hit_io;
            end
        end
    end
endmodule

// File: rtl/range_remote_xlate.sv
// Range-based remote address translator (top).
// One shared range table, with separate matchers and handshake paths
// for instruction fetches and data accesses.
// Assumes the network side answers each request with exactly one completion strobe.
module range_remote_xlate #(
    parameter int N_ENTRY = 4,
    parameter int AW      = 32,
    parameter int HOST_W  = 8,
    localparam int SLOT_W = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1,
    localparam int HIT_W  = $clog2(N_ENTRY + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic [AW-1:0]     cfg_lo,
    input  logic [AW-1:0]     cfg_hi,
    input  logic [HOST_W-1:0] cfg_host,
    input  logic              cfg_io,
    input  logic              cfg_valid,
    input  logic [AW-1:0]     if_addr,
    input  logic              if_strobe,
    output logic [HIT_W-1:0]  if_hit,
    output logic              if_remote,
    output logic              if_rdy_n,
    output logic              if_net_req,
    output logic [HOST_W-1:0] if_net_host,
    output logic [AW-1:0]     if_net_addr,
    output logic              if_net_io,
    input  logic              if_net_cmp,
    input  logic [AW-1:0]     dt_addr,
    input  logic              dt_strobe,
    output logic [HIT_W-1:0]  dt_hit,
    output logic              dt_remote,
    output logic              dt_rdy_n,
    output logic              dt_net_req,
    output logic [HOST_W-1:0] dt_net_host,
    output logic [AW-1:0]     dt_net_addr,
    output logic              dt_net_io,
    input  logic              dt_net_cmp
);
    logic [N_ENTRY-1:0][AW-1:0]     t_lo;
    logic [N_ENTRY-1:0][AW-1:0]     t_hi;
    logic [N_ENTRY-1:0][HOST_W-1:0] t_host;
    logic [N_ENTRY-1:0]             t_io;
    logic [N_ENTRY-1:0]             t_valid;
    logic [HOST_W-1:0]              if_mhost, dt_mhost;
    logic                           if_mio, dt_mio;

    xlate_table #(.N_ENTRY(N_ENTRY), .AW(AW), .HOST_W(HOST_W)) u_table (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .slot(cfg_slot),
        .lo_in(cfg_lo), .hi_in(cfg_hi), .host_in(cfg_host),
        .io_in(cfg_io), .valid_in(cfg_valid),
        .lo(t_lo), .hi(t_hi), .host(t_host), .io(t_io), .valid(t_valid)
    );

    xlate_match #(.N_ENTRY(N_ENTRY), .AW(AW), .HOST_W(HOST_W)) u_if_match (
        .addr(if_addr), .lo(t_lo), .hi(t_hi), .host(t_host), .io(t_io),
        .valid(t_valid), .hit_num(if_hit), .hit_host(if_mhost), .hit_io(if_mio)
    );

    xlate_match #(.N_ENTRY(N_ENTRY), .AW(AW), .HOST_W(HOST_W)) u_dt_match (
        .addr(dt_addr), .lo(t_lo), .hi(t_hi), .host(t_host), .io(t_io),
        .valid(t_valid), .hit_num(dt_hit), .hit_host(dt_mhost), .hit_io(dt_mio)
    );

    assign if_remote = (if_hit != '0);
    assign dt_remote = (dt_hit != '0);

    xlate_path #(.AW(AW), .HOST_W(HOST_W)) u_if_path (
        .clk(clk), .rst_n(rst_n), .addr(if_addr), .strobe(if_strobe),
        .remote(if_remote), .hit_host(if_mhost), .hit_io(if_mio),
        .net_cmp(if_net_cmp), .rdy_n(if_rdy_n), .net_req(if_net_req),
        .net_host(if_net_host), .net_addr(if_net_addr), .net_io(if_net_io)
    );

    xlate_path #(.AW(AW), .HOST_W(HOST_W)) u_dt_path (
        .clk(clk), .rst_n(rst_n), .addr(dt_addr), .strobe(dt_strobe),
        .remote(dt_remote), .hit_host(dt_mhost), .hit_io(dt_mio),
        .net_cmp(dt_net_cmp), .rdy_n(dt_rdy_n), .net_req(dt_net_req),
        .net_host(dt_net_host), .net_addr(dt_net_addr), .net_io(dt_net_io)
    );
endmodule

// File: rtl/xlate_checker.sv
// Assertion checker for range_remote_xlate, attached with bind.
// Observes ports only.
module xlate_checker #(
    parameter int N_ENTRY = 4,
    parameter int AW      = 32,
    parameter int HOST_W  = 8,
    localparam int HIT_W  = $clog2(N_ENTRY + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [AW-1:0]    if_addr,
    input logic             if_strobe,
    input logic [HIT_W-1:0] if_hit,
    input logic             if_remote,
    input logic             if_rdy_n,
    input logic             if_net_req,
    input logic [AW-1:0]    if_net_addr,
    input logic [AW-1:0]    dt_addr,
    input logic             dt_strobe,
    input logic [HIT_W-1:0] dt_hit,
    input logic             dt_remote,
    input logic             dt_rdy_n,
    input logic             dt_net_req,
    input logic [AW-1:0]    dt_net_addr
);
    // R1: the hit number never exceeds the entry count.
    a_r1_hit_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(if_hit) <= N_ENTRY && int'(dt_hit) <= N_ENTRY);

    // R6: a request lasts one cycle.
    a_r6_if_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        if_net_req |=> !if_net_req);
    a_r6_dt_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dt_net_req |=> !dt_net_req);

    // R6: a request follows a stalled, strobed remote access and carries its address.
    a_r6_if_req_cause: assert property (@(posedge clk) disable iff (!rst_n)
        if_net_req |-> ($past(if_strobe) && $past(if_remote) && $past(if_rdy_n)
                        && if_net_addr == $past(if_addr)));
    a_r6_dt_req_cause: assert property (@(posedge clk) disable iff (!rst_n)
        dt_net_req |-> ($past(dt_strobe) && $past(dt_remote) && $past(dt_rdy_n)
                        && dt_net_addr == $past(dt_addr)));

    // R5: the stall is still held while the request is on the wire.
    a_r5_if_stall_held: assert property (@(posedge clk) disable iff (!rst_n)
        if_net_req |-> if_rdy_n);
    a_r5_dt_stall_held: assert property (@(posedge clk) disable iff (!rst_n)
        dt_net_req |-> dt_rdy_n);
endmodule

bind range_remote_xlate xlate_checker #(.N_ENTRY(N_ENTRY), .AW(AW), .HOST_W(HOST_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .if_addr(if_addr), .if_strobe(if_strobe), .if_hit(if_hit), .if_remote(if_remote),
    .if_rdy_n(if_rdy_n), .if_net_req(if_net_req), .if_net_addr(if_net_addr),
    .dt_addr(dt_addr), .dt_strobe(dt_strobe), .dt_hit(dt_hit), .dt_remote(dt_remote),
    .dt_rdy_n(dt_rdy_n), .dt_net_req(dt_net_req), .dt_net_addr(dt_net_addr)
);

// File: tb/range_remote_xlate_bench.sv
// Self-checking bench for range_remote_xlate.
module range_remote_xlate_bench;
    localparam int N  = 4;
    localparam int AW = 32;
    localparam int HW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_slot = '0;
    logic [AW-1:0] cfg_lo = '0, cfg_hi = '0;
    logic [HW-1:0] cfg_host = '0;
    logic cfg_io = 1'b0, cfg_valid = 1'b0;
    logic [AW-1:0] addr [2];
    logic strobe [2];
    logic cmp [2];
    logic [2:0] hit [2];
    logic remote [2];
    logic rdy_n [2];
    logic req [2];
    logic [HW-1:0] rhost [2];
    logic [AW-1:0] raddr [2];
    logic rio [2];

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    logic [AW-1:0] m_lo [N];
    logic [AW-1:0] m_hi [N];
    logic [HW-1:0] m_host [N];
    logic m_io [N];
    logic m_val [N];

    always #5 clk = ~clk;

    range_remote_xlate #(.N_ENTRY(N), .AW(AW), .HOST_W(HW)) u_range_remote_xlate (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
        .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_host(cfg_host), .cfg_io(cfg_io),
        .cfg_valid(cfg_valid),
        .if_addr(addr[0]), .if_strobe(strobe[0]), .if_hit(hit[0]), .if_remote(remote[0]),
        .if_rdy_n(rdy_n[0]), .if_net_req(req[0]), .if_net_host(rhost[0]),
        .if_net_addr(raddr[0]), .if_net_io(rio[0]), .if_net_cmp(cmp[0]),
        .dt_addr(addr[1]), .dt_strobe(strobe[1]), .dt_hit(hit[1]), .dt_remote(remote[1]),
        .dt_rdy_n(rdy_n[1]), .dt_net_req(req[1]), .dt_net_host(rhost[1]),
        .dt_net_addr(raddr[1]), .dt_net_io(rio[1]), .dt_net_cmp(cmp[1])
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_hit(input logic [AW-1:0] a);
        for (int i = 0; i < N; i++)
            if (m_val[i] && m_lo[i] <= a && a <= m_hi[i]) return i + 1;
        return 0;
    endfunction

    task automatic load(input int s, input logic [AW-1:0] lo, input logic [AW-1:0] hi,
                        input logic [HW-1:0] h, input logic io, input logic v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_slot = 2'(s); cfg_lo = lo; cfg_hi = hi;
        cfg_host = h; cfg_io = io; cfg_valid = v;
        m_lo[s] = lo; m_hi[s] = hi; m_host[s] = h; m_io[s] = io; m_val[s] = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // R1 R2 R3 R4: combinational lookup without strobe.
    task automatic probe(input int p, input logic [AW-1:0] a);
        int e;
        addr[p] = a; strobe[p] = 1'b0;
        #1;
        e = exp_hit(a);
        chk(p == 0 ? "R1/R2/R3 if_hit" : "R1/R2/R3 dt_hit", 64'(hit[p]), 64'(e));
        chk("R4 remote flag", 64'(remote[p]), 64'(e != 0));
        chk("R5 no stall without strobe", 64'(rdy_n[p]), 64'd0);
    endtask

    // R5 R6 R7: one strobed access with completion after d wait cycles.
    task automatic access(input int p, input logic [AW-1:0] a, input int d);
        int e;
        @(negedge clk);
        addr[p] = a; strobe[p] = 1'b1;
        #1;
        e = exp_hit(a);
        chk("R1 hit on strobe", 64'(hit[p]), 64'(e));
        chk("R5 stall on remote strobe", 64'(rdy_n[p]), 64'(e != 0));
        if (e == 0) begin
            @(negedge clk);
            #1;
            chk("R6 no request for local", 64'(req[p]), 64'd0);
            strobe[p] = 1'b0;
            return;
        end
        @(negedge clk);
        #1;
        chk("R6 request pulse", 64'(req[p]), 64'd1);
        chk("R6 request host", 64'(rhost[p]), 64'(m_host[e-1]));
        chk("R6 request addr", 64'(raddr[p]), 64'(a));
        chk("R6 request kind", 64'(rio[p]), 64'(m_io[e-1]));
        chk("R5 stall while outstanding", 64'(rdy_n[p]), 64'd1);
        for (int k = 0; k < d; k++) begin
            @(negedge clk);
            #1;
            chk("R6 request one cycle", 64'(req[p]), 64'd0);
            chk("R5 stall held", 64'(rdy_n[p]), 64'd1);
        end
        cmp[p] = 1'b1;
        @(negedge clk);
        cmp[p] = 1'b0;
        #1;
        chk("R7 grant after completion", 64'(rdy_n[p]), 64'd0);
        chk("R7 no request in grant", 64'(req[p]), 64'd0);
        strobe[p] = 1'b0;
        @(negedge clk);
        #1;
        chk("R7 idle after grant", 64'(rdy_n[p]), 64'd0);
        chk("R7 no request after grant", 64'(req[p]), 64'd0);
    endtask

    function automatic logic [AW-1:0] pick_addr();
        int s;
        s = $urandom % N;
        case ($urandom % 3)
            0: return $urandom;
            1: return m_lo[s] + AW'($urandom % 5) - AW'(2);
            default: return m_hi[s] + AW'($urandom % 5) - AW'(2);
        endcase
    endfunction

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int p = 0; p < 2; p++) begin
            addr[p] = '0; strobe[p] = 1'b0; cmp[p] = 1'b0;
        end
        for (int i = 0; i < N; i++) begin
            m_lo[i] = '0; m_hi[i] = '0; m_host[i] = '0; m_io[i] = 1'b0; m_val[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3: reset state.
        addr[0] = 32'h0; addr[1] = 32'h1234;
        #1;
        chk("R3 reset hit if", 64'(hit[0]), 64'd0);
        chk("R3 reset hit dt", 64'(hit[1]), 64'd0);
        chk("R5 reset ready", 64'(rdy_n[0] | rdy_n[1]), 64'd0);
        chk("R6 reset request", 64'(req[0] | req[1]), 64'd0);

        // Directed table with overlap, invalid slot, single-address range.
        load(0, 32'h0000_1000, 32'h0000_1FFF, 8'h05, 1'b0, 1'b1);
        load(1, 32'h0000_1800, 32'h0000_27FF, 8'h09, 1'b1, 1'b1);
        load(2, 32'h0000_0000, 32'hFFFF_FFFF, 8'h77, 1'b0, 1'b0);
        load(3, 32'h8000_0000, 32'h8000_0000, 8'h33, 1'b1, 1'b1);
        // R9: slot s reports s+1 right after the write.
        probe(0, 32'h8000_0000);
        chk("R9 slot 3 reports 4", 64'(hit[0]), 64'd4);
        probe(0, 32'h0000_0FFF);  // R1 below lower bound
        probe(0, 32'h0000_1000);  // R1 lower bound included
        probe(0, 32'h0000_1FFF);  // R1 upper bound included
        probe(1, 32'h0000_1800);  // R2 overlap -> entry 1
        chk("R2 lowest wins", 64'(hit[1]), 64'd1);
        probe(1, 32'h0000_2000);
        probe(1, 32'h0000_27FF);
        probe(1, 32'h0000_2800);  // R3 invalid wide entry gives 0
        chk("R3 invalid entry no hit", 64'(hit[1]), 64'd0);
        probe(0, 32'h8000_0001);
        probe(0, 32'h7FFF_FFFF);

        // R5 R6 R7 directed handshakes.
        access(0, 32'h0000_1800, 0);
        access(1, 32'h0000_2400, 3);
        access(0, 32'h0000_0100, 0);

        // R7: completion while idle has no effect.
        @(negedge clk);
        cmp[1] = 1'b1;
        @(negedge clk);
        cmp[1] = 1'b0;
        #1;
        chk("R7 idle completion ignored rdy", 64'(rdy_n[1]), 64'd0);
        chk("R7 idle completion ignored req", 64'(req[1]), 64'd0);
        access(1, 32'h8000_0000, 1);

        // R8: instruction stalls while a local data access proceeds.
        @(negedge clk);
        addr[0] = 32'h0000_1004; strobe[0] = 1'b1;
        addr[1] = 32'h0000_5000; strobe[1] = 1'b1;
        #1;
        chk("R8 if stalls", 64'(rdy_n[0]), 64'd1);
        chk("R8 dt not stalled", 64'(rdy_n[1]), 64'd0);
        @(negedge clk);
        #1;
        chk("R8 dt no request", 64'(req[1]), 64'd0);
        chk("R8 if request", 64'(req[0]), 64'd1);
        cmp[1] = 1'b1;  // completion on the other path must not release this one
        @(negedge clk);
        cmp[1] = 1'b0;
        #1;
        chk("R8 other completion keeps stall", 64'(rdy_n[0]), 64'd1);
        cmp[0] = 1'b1;
        @(negedge clk);
        cmp[0] = 1'b0;
        #1;
        chk("R8 own completion grants", 64'(rdy_n[0]), 64'd0);
        strobe[0] = 1'b0; strobe[1] = 1'b0;
        @(negedge clk);

        // Random lookups and handshakes on fresh random tables.
        for (int round = 0; round < 4; round++) begin
            for (int s = 0; s < N; s++) begin
                logic [AW-1:0] b, w;
                b = {20'h0, 12'($urandom)};
                w = AW'($urandom % 1024);
                load(s, b, b + w, 8'($urandom), 1'($urandom), ($urandom % 4) != 0);
            end
            for (int k = 0; k < 300; k++) begin
                logic [AW-1:0] a;
                a = pick_addr();
                if (($urandom % 2) == 0) a = {20'h0, 12'(a)};
                @(negedge clk);
                probe(k % 2, a);
            end
            for (int k = 0; k < 20; k++) begin
                logic [AW-1:0] a;
                a = pick_addr();
                access(k % 2, a, $urandom % 4);
            end
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule